// File: doc/BRIEF.md
# Single-Channel Byte DMA Engine with Source Window Reload

This block moves bytes from a source address to a destination address. Each transfer is a read from the source followed by a write of the same byte to the destination, and both accesses wait for the memory's ready signal. Software sets up the source address, the destination address, the number of transfers, a reload length and a control word through a small register port. It then sets the channel enable bit. A peripheral request line paces the work. In cycle-steal mode each request produces one transfer. In burst mode a single request starts back-to-back transfers that run until the count is exhausted.

The reload feature lets a short, repeating source region be sampled many times into a longer destination buffer. After every reload-length transfers the source pointer jumps back to the start value that was captured at enable. The destination pointer and the remaining count keep advancing. When the count runs out, the channel drops its enable bit and raises a sticky done flag. If the interrupt enable bit is set, the interrupt output asserts while the done flag is set. A global master enable gates everything.

Top module: `dma_reload_chan`

## Requirements
- R1: After reset, every register reads as zero, and `mem_rd`, `mem_wr` and `irq` are low.
- R2: A transfer drives `mem_rd` at the current source address until `mem_ready` is high, then drives `mem_wr` at the current destination address with the captured byte until `mem_ready` is high. `mem_rd` and `mem_wr` are never high together, and address and data stay stable while an access is stalled.
- R3: The control register has these fields: bit 1 makes the source increment and bit 2 makes the destination increment. An incrementing side advances by 1 after each transfer, and a fixed side keeps its address. The current source and destination addresses can be read back at offsets 0 and 1.
- R4: The remaining count (offset 2) decrements by exactly 1 per completed transfer. When it reaches zero, control bit 0 (enable) clears and control bit 6 (done) sets. Both are visible when control (offset 3) is read.
- R5: `irq` is high while done is set and control bit 4 (interrupt enable) is set, and it stays low when bit 4 is clear. Writing control with bit 6 set clears done, and `irq` with it.
- R6: When control bit 3 is 0 (cycle-steal), each request pulse yields exactly one transfer and the bus returns to idle. One request that arrives while a transfer is in progress is held and served afterwards.
- R7: When control bit 3 is 1 (burst), a single request runs all remaining transfers back to back. With zero-wait memory, N transfers occupy exactly 2N consecutive bus cycles.
- R8: When control bit 5 (reload) is set and the reload length (offset 4) L is nonzero, the source address returns to its start value after every L transfers. The destination and the count keep going. With L equal to 0, no reload occurs.
- R9: No transfer starts unless master enable (offset 5, bit 0) and channel enable are both set. Requests that arrive while the channel is gated are discarded.
- R10: The start source address, start destination, count and reload length are captured when control is written with bit 0 set while the channel is disabled. Later writes to those registers do not alter a run in progress.
- R11: The reload length and master enable registers read back the values written, and control reads back its mode bits in the positions above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data valid the next cycle |
| reg_addr | input | 3 | Register offset (0 src, 1 dst, 2 count, 3 control, 4 reload length, 5 master) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| dreq | input | 1 | Peripheral transfer request |
| mem_addr | output | 32 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_ready | input | 1 | Memory access completes in a cycle where this is high |
| irq | output | 1 | End-of-count interrupt |

## Verification
A request sampled at a clock edge raises `mem_rd` one cycle later. The write strobe follows the cycle after the read is accepted. The destination byte, the count and the addresses update at the edge where the write is accepted, and done and `irq` appear in the cycle after the final write. Register reads return data one cycle after the strobe, so the bench samples them at the falling edge after the capturing rising edge. After each stimulus the bench waits for the counted write handshakes, or for a fixed settle of several cycles, before it reads anything back. The burst timing check counts the rising edges that carry a strobe and compares them to exactly twice the transfer count.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam logic [2:0] REG_SRC    = 3'd0;
  localparam logic [2:0] REG_DST    = 3'd1;
  localparam logic [2:0] REG_CNT    = 3'd2;
  localparam logic [2:0] REG_CTRL   = 3'd3;
  localparam logic [2:0] REG_RELOAD = 3'd4;
  localparam logic [2:0] REG_MASTER = 3'd5;

  localparam int CB_EN     = 0;
  localparam int CB_SINC   = 1;
  localparam int CB_DINC   = 2;
  localparam int CB_BURST  = 3;
  localparam int CB_IRQEN  = 4;
  localparam int CB_RLDEN  = 5;
  localparam int CB_DONE   = 6;

  typedef struct packed {
    logic rld_en;
    logic irq_en;
    logic burst;
    logic dst_inc;
    logic src_inc;
    logic en;
  } ctrl_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'b00,
    SEQ_RD   = 2'b01,
    SEQ_WR   = 2'b10
  } seq_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int RLD_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              end_evt,
  input  logic [ADDR_W-1:0] src_cur,
  input  logic [ADDR_W-1:0] dst_cur,
  input  logic [CNT_W-1:0]  cnt_cur,
  output ctrl_t             ctrl,
  output logic              master,
  output logic              done,
  output logic [ADDR_W-1:0] src_prog,
  output logic [ADDR_W-1:0] dst_prog,
  output logic [CNT_W-1:0]  cnt_prog,
  output logic [RLD_W-1:0]  rld_prog,
  output logic              load
);
  logic wr_ctrl;

  assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
  assign load    = wr_ctrl && reg_wdata[CB_EN] && !ctrl.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      master   <= 1'b0;
      src_prog <= '0;
      dst_prog <= '0;
      cnt_prog <= '0;
      rld_prog <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          REG_SRC:    src_prog <= reg_wdata[ADDR_W-1:0];
          REG_DST:    dst_prog <= reg_wdata[ADDR_W-1:0];
          REG_CNT:    cnt_prog <= reg_wdata[CNT_W-1:0];
          REG_RELOAD: rld_prog <= reg_wdata[RLD_W-1:0];
          REG_MASTER: master   <= reg_wdata[0];
          REG_CTRL: begin
            ctrl.en      <= reg_wdata[CB_EN];
            ctrl.src_inc <= reg_wdata[CB_SINC];
            ctrl.dst_inc <= reg_wdata[CB_DINC];
            ctrl.burst   <= reg_wdata[CB_BURST];
            ctrl.irq_en  <= reg_wdata[CB_IRQEN];
            ctrl.rld_en  <= reg_wdata[CB_RLDEN];
          end
          default: ;
        endcase
      end
      // count exhaustion wins over a software write of the enable bit
      if (end_evt) ctrl.en <= 1'b0;
    end
  end

  // sticky end flag, write-one-to-clear, set wins over clear
  always_ff @(posedge clk) begin
    if (rst)                              done <= 1'b0;
    else if (end_evt)                     done <= 1'b1;
    else if (wr_ctrl && reg_wdata[CB_DONE]) done <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        REG_SRC:    reg_rdata <= REG_W'(src_cur);
        REG_DST:    reg_rdata <= REG_W'(dst_cur);
        REG_CNT:    reg_rdata <= REG_W'(cnt_cur);
        REG_CTRL:   reg_rdata <= REG_W'({done, ctrl.rld_en, ctrl.irq_en, ctrl.burst,
                                         ctrl.dst_inc, ctrl.src_inc, ctrl.en});
        REG_RELOAD: reg_rdata <= REG_W'(rld_prog);
        REG_MASTER: reg_rdata <= REG_W'(master);
        default:    reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int RLD_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] src_prog,
  input  logic [ADDR_W-1:0] dst_prog,
  input  logic [CNT_W-1:0]  cnt_prog,
  input  logic [RLD_W-1:0]  rld_prog,
  input  logic              src_inc,
  input  logic              dst_inc,
  input  logic              rld_en,
  output logic [ADDR_W-1:0] src_cur,
  output logic [ADDR_W-1:0] dst_cur,
  output logic [CNT_W-1:0]  cnt_cur,
  output logic              last
);
  logic [ADDR_W-1:0] src_base;
  logic [RLD_W-1:0]  rld_base;
  logic [RLD_W-1:0]  rld_left;
  logic              wrap;

  assign wrap = rld_en && (rld_base != '0) && (rld_left == RLD_W'(1));
  assign last = (cnt_cur == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      src_base <= '0;
      src_cur  <= '0;
      dst_cur  <= '0;
      cnt_cur  <= '0;
      rld_base <= '0;
      rld_left <= '0;
    end else if (load) begin
      src_base <= src_prog;
      src_cur  <= src_prog;
      dst_cur  <= dst_prog;
      cnt_cur  <= cnt_prog;
      rld_base <= rld_prog;
      rld_left <= rld_prog;
    end else if (step) begin
      cnt_cur <= cnt_cur - 1'b1;
      if (dst_inc) dst_cur <= dst_cur + 1'b1;
      if (wrap) begin
        src_cur  <= src_base;
        rld_left <= rld_base;
      end else begin
        if (src_inc) src_cur <= src_cur + 1'b1;
        rld_left <= rld_left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dreq,
  input  logic       go_ok,
  input  logic       burst,
  input  logic       last,
  input  logic       mem_ready,
  input  logic [7:0] mem_rdata,
  output logic       mem_rd,
  output logic       mem_wr,
  output logic [7:0] mem_wdata,
  output logic       step,
  output logic       end_evt
);
  seq_t       state;
  logic       pend;
  logic       req;
  logic [7:0] data_q;

  assign req       = pend || dreq;
  assign mem_rd    = state[0];
  assign mem_wr    = state[1];
  assign mem_wdata = data_q;
  assign step      = (state == SEQ_WR) && mem_ready;
  assign end_evt   = step && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SEQ_IDLE;
      data_q <= '0;
    end else begin
      case (state)
        SEQ_IDLE: if (go_ok && req) state <= SEQ_RD;
        SEQ_RD: if (mem_ready) begin
          data_q <= mem_rdata;
          state  <= SEQ_WR;
        end
        SEQ_WR: if (mem_ready) begin
          if (!last && burst && go_ok) state <= SEQ_RD;
          else                         state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // one held request; dropped whenever the channel is gated off
  always_ff @(posedge clk) begin
    if (rst)                                   pend <= 1'b0;
    else if (!go_ok)                           pend <= 1'b0;
    else if (state == SEQ_IDLE && req)         pend <= 1'b0;
    else if (dreq)                             pend <= 1'b1;
  end
endmodule

// File: rtl/dma_reload_chan.sv
module dma_reload_chan
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int RLD_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              dreq,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ready,
  output logic              irq
);
  ctrl_t             ctrl;
  logic              master;
  logic              done_flag;
  logic              load;
  logic              step;
  logic              end_evt;
  logic              last;
  logic              gate_ok;
  logic              go_ok;
  logic [ADDR_W-1:0] src_prog, dst_prog, src_cur, dst_cur;
  logic [CNT_W-1:0]  cnt_prog, cnt_cur;
  logic [RLD_W-1:0]  rld_prog;

  assign gate_ok  = master && ctrl.en;
  assign go_ok    = gate_ok && (cnt_cur != '0);
  assign mem_addr = mem_wr ? dst_cur : src_cur;
  assign irq      = done_flag && ctrl.irq_en;

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RLD_W(RLD_W), .REG_W(REG_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .end_evt(end_evt),
    .src_cur(src_cur), .dst_cur(dst_cur), .cnt_cur(cnt_cur), .ctrl(ctrl),
    .master(master), .done(done_flag), .src_prog(src_prog), .dst_prog(dst_prog),
    .cnt_prog(cnt_prog), .rld_prog(rld_prog), .load(load)
  );

  dma_addr_gen #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RLD_W(RLD_W)) u_agen (
    .clk(clk), .rst(rst), .load(load), .step(step), .src_prog(src_prog),
    .dst_prog(dst_prog), .cnt_prog(cnt_prog), .rld_prog(rld_prog),
    .src_inc(ctrl.src_inc), .dst_inc(ctrl.dst_inc), .rld_en(ctrl.rld_en),
    .src_cur(src_cur), .dst_cur(dst_cur), .cnt_cur(cnt_cur), .last(last)
  );

  dma_seq u_seq (
    .clk(clk), .rst(rst), .dreq(dreq), .go_ok(go_ok), .burst(ctrl.burst),
    .last(last), .mem_ready(mem_ready), .mem_rdata(mem_rdata), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .step(step), .end_evt(end_evt)
  );
endmodule

// File: rtl/dma_reload_chan_chk.sv
module dma_reload_chan_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic [7:0]        mem_rdata,
  input logic              gate,
  input logic              done,
  input logic [CNT_W-1:0]  cnt
);
  assert_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_rd_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  assert_wr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

  assert_byte_fwd_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && mem_ready) |=> (mem_wr && mem_wdata == $past(mem_rdata)));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && mem_ready) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  assert_done_at_end_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(mem_wr) && $past(mem_ready) && $past(cnt) == CNT_W'(1)));

  assert_gated_start_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !$past(mem_rd) && !$past(mem_wr)) |-> $past(gate));
endmodule

bind dma_reload_chan dma_reload_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
  .gate(gate_ok), .done(done_flag), .cnt(cnt_cur)
);

// File: tb/dma_reload_chan_tb.sv
module dma_reload_chan_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dreq = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_rd, mem_wr, mem_ready;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        irq;

  logic        stall = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  mem [0:4095];
  logic [7:0]  shd [0:4095];
  int          nxfer = 0, busy = 0, nchk = 0, nfail = 0;

  typedef struct packed {
    logic [11:0] src; logic [11:0] dst; logic [15:0] cnt;
    logic si; logic di; logic bu; logic re; logic [7:0] rl; logic st;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{12'h010, 12'h800, 16'd8,  1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 1'b0},
    '{12'h020, 12'h900, 16'd6,  1'b0, 1'b1, 1'b0, 1'b0, 8'd0, 1'b1},
    '{12'h040, 12'hA00, 16'd12, 1'b1, 1'b1, 1'b1, 1'b1, 8'd4, 1'b0},
    '{12'h060, 12'hB00, 16'd5,  1'b1, 1'b0, 1'b1, 1'b0, 8'd0, 1'b1},
    '{12'h080, 12'hC00, 16'd10, 1'b1, 1'b1, 1'b0, 1'b1, 8'd3, 1'b1},
    '{12'h0A0, 12'hD00, 16'd6,  1'b1, 1'b1, 1'b1, 1'b1, 8'd0, 1'b0}
  };

  always #10 clk = ~clk;

  dma_reload_chan u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .irq(irq)
  );

  assign mem_ready = (mem_rd || mem_wr) && (!stall || tick);
  assign mem_rdata = mem[mem_addr[11:0]];

  always @(posedge clk) begin
    tick <= ~tick;
    if (mem_rd || mem_wr) busy <= busy + 1;
    if (mem_wr && mem_ready) begin
      mem[mem_addr[11:0]] <= mem_wdata;
      nxfer <= nxfer + 1;
    end
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37) + (i >> 4) + 5);
  endfunction

  function automatic logic [31:0] ctl(input logic en, si, di, bu, ie, re);
    return {26'd0, re, ie, bu, di, si, en};
  endfunction

  function automatic int soff(input vec_t v, input int k);
    if (!v.si) return 0;
    if (v.re && v.rl != 0) return k % int'(v.rl);
    return k;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_xfer(input int target);
    for (int t = 0; t < 4000 && nxfer < target; t++) @(negedge clk);
  endtask

  task automatic fill();
    for (int i = 0; i < 4096; i++) begin mem[i] = pat(i); shd[i] = pat(i); end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    logic [31:0] d;
    int base, first_busy, mism;
    fill();
    stall = v.st;
    wreg(3'd0, 32'(v.src)); wreg(3'd1, 32'(v.dst)); wreg(3'd2, 32'(v.cnt));
    wreg(3'd4, 32'(v.rl));  wreg(3'd5, 32'd1);
    wreg(3'd3, ctl(1'b1, v.si, v.di, v.bu, 1'b1, v.re));
    base = nxfer;
    first_busy = busy;
    if (v.bu) begin
      pulse();
      wait_xfer(base + int'(v.cnt));
    end else begin
      for (int k = 0; k < int'(v.cnt); k++) begin
        pulse();
        wait_xfer(base + k + 1);
      end
    end
    settle(3);
    // R6 / R7: transfer count at the bus
    check($sformatf("R6 vec%0d transfers", idx), 32'(nxfer - base), 32'(v.cnt));
    if (v.bu && !v.st)
      check($sformatf("R7 vec%0d burst bus cycles", idx), 32'(busy - first_busy), 32'(2 * v.cnt));
    for (int k = 0; k < int'(v.cnt); k++)
      shd[int'(v.dst) + (v.di ? k : 0)] = pat(int'(v.src) + soff(v, k));
    mism = 0;
    for (int k = 0; k < int'(v.cnt); k++) begin
      int a;
      a = int'(v.dst) + (v.di ? k : 0);
      if (mem[a] !== shd[a]) mism++;
    end
    check($sformatf("R2 R8 vec%0d destination bytes", idx), 32'(mism), 32'd0);
    check($sformatf("R5 vec%0d irq", idx), 32'(irq), 32'd1);
    rreg(3'd2, d); check($sformatf("R4 vec%0d count zero", idx), d, 32'd0);
    rreg(3'd3, d); check($sformatf("R4 vec%0d ctrl done", idx), d,
                         ctl(1'b0, v.si, v.di, v.bu, 1'b1, v.re) | 32'h40);
    rreg(3'd1, d); check($sformatf("R3 vec%0d final dst", idx), d,
                         32'(v.dst) + (v.di ? 32'(v.cnt) : 32'd0));
    rreg(3'd0, d); check($sformatf("R3 R8 vec%0d final src", idx), d,
                         32'(v.src) + 32'(soff(v, int'(v.cnt))));
    wreg(3'd3, 32'h40);
    settle(1);
    check($sformatf("R5 vec%0d irq cleared", idx), 32'(irq), 32'd0);
    stall = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int b;
    fill();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle(1);

    // R1 reset state
    check("R1 mem_rd", 32'(mem_rd), 32'd0);
    check("R1 mem_wr", 32'(mem_wr), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    for (int r = 0; r < 6; r++) begin
      rreg(3'(r), d);
      check($sformatf("R1 reg%0d reset", r), d, 32'd0);
    end

    // R11 readback
    wreg(3'd4, 32'h0000_1234); rreg(3'd4, d); check("R11 reload readback", d, 32'h1234);
    wreg(3'd5, 32'd1);         rreg(3'd5, d); check("R11 master readback", d, 32'd1);
    wreg(3'd3, ctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1));
    rreg(3'd3, d); check("R11 ctrl readback", d, 32'h2A);

    // R9 gating by master enable
    wreg(3'd5, 32'd0);
    wreg(3'd0, 32'h200); wreg(3'd1, 32'hE80); wreg(3'd2, 32'd3); wreg(3'd4, 32'd0);
    wreg(3'd3, ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
    b = nxfer;
    pulse(); settle(20);
    check("R9 no transfer with master off", 32'(nxfer - b), 32'd0);
    wreg(3'd5, 32'd1); settle(20);
    check("R9 gated request discarded", 32'(nxfer - b), 32'd0);
    rreg(3'd2, d); check("R9 count untouched", d, 32'd3);
    // R9 gating by channel enable
    wreg(3'd3, ctl(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
    pulse(); settle(20);
    check("R9 no transfer with channel off", 32'(nxfer - b), 32'd0);

    // R6 single request, then one held request, cycle-steal with stalls
    stall = 1'b1;
    wreg(3'd0, 32'h200); wreg(3'd1, 32'hE80); wreg(3'd2, 32'd4);
    wreg(3'd3, ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
    b = nxfer;
    pulse(); settle(20);
    check("R6 one request one transfer", 32'(nxfer - b), 32'd1);
    check("R6 bus idle after transfer", 32'(mem_rd | mem_wr), 32'd0);
    rreg(3'd2, d); check("R6 count after one", d, 32'd3);
    pulse(); pulse(); settle(30);
    check("R6 held request served", 32'(nxfer - b), 32'd3);
    pulse(); settle(20);
    rreg(3'd3, d); check("R4 R5 done without irq enable", d, 32'h47 & 32'h46);
    check("R5 irq stays low when disabled", 32'(irq), 32'd0);
    check("R3 E80 window byte", 32'(mem[12'hE83]), 32'(pat(12'h203)));
    wreg(3'd3, 32'h40);
    stall = 1'b0;

    // R10 latched start values with reload during burst
    fill();
    wreg(3'd0, 32'h100); wreg(3'd1, 32'hF00); wreg(3'd2, 32'd4); wreg(3'd4, 32'd2);
    wreg(3'd3, ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1));
    wreg(3'd0, 32'h300); wreg(3'd4, 32'd7); wreg(3'd1, 32'h000);
    b = nxfer;
    pulse(); wait_xfer(b + 4); settle(3);
    check("R10 byte0", 32'(mem[12'hF00]), 32'(pat(12'h100)));
    check("R10 byte1", 32'(mem[12'hF01]), 32'(pat(12'h101)));
    check("R10 R8 byte2 reloaded", 32'(mem[12'hF02]), 32'(pat(12'h100)));
    check("R10 R8 byte3", 32'(mem[12'hF03]), 32'(pat(12'h101)));
    wreg(3'd3, 32'h40);

    // vector table
    for (int i = 0; i < 6; i++) run_vec(VECS[i], i);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule